// File: doc/BRIEF.md
# Double-Rank Crosspoint Configuration Bank

This block holds the routing configuration for a switch matrix with 33 inputs and 17 outputs. Every output has two registers. The first is a staging word that the host writes one output at a time. The second is an active word that drives the matrix. A single update strobe copies all staging words into the active rank on the same clock edge, so a complete new routing pattern takes effect at once.

Each active word has two fields. Bit 6 is the enable for that output, and bits 5:0 select the input that feeds it. The host uses a parallel interface with active-low strobes for select, write, read and update. The data bus is split into an input half and an output half, with an output-enable that controls the pad driver. A readback returns the active word of the addressed output. An active-low global disable clears every output enable without waiting for a clock. It does not depend on chip-select, and it leaves the staging rank and the select fields alone. All 17 active words go to the matrix as parallel signals.

Top module: `xpt_cfg_bank`

## Requirements
- R1: When cs_n and we_n are both low, data_i is stored in the staging word of output addr on the rising clock edge. A write by itself never changes en_o or sel_o.
- R2: When cs_n and upd_n are both low, all 17 staging words are copied into the active rank on the rising clock edge. In each word, bit 6 goes to en_o and bits 5:0 go to that output's 6-bit slice of sel_o.
- R3: When cs_n and re_n are both low, data_oe is 1 and data_o shows the active word of output addr, as {enable, select[5:0]}, in the same cycle with no clock delay.
- R4: When cs_n or re_n is high, data_oe is 0 and data_o is zero.
- R5: When cs_n is high, write and update strobes have no effect, and en_o and sel_o hold their values.
- R6: A write to an address from 17 to 31 changes no staging word.
- R7: A readback of an address from 17 to 31 returns all zeros with data_oe set.
- R8: While rst_n is low, every bit of en_o is 0. The clear happens at once, with no clock edge, whatever the value of cs_n. The select fields keep their values.
- R9: Global disable leaves the staging rank untouched, so an update after rst_n is released restores the enables held in staging.
- R10: When an update happens while rst_n is low, the select fields load from staging and the enables stay 0.
- R11: When a write and an update fall on the same edge, the update copies the staging contents from before that edge. The new word reaches the active rank at the next update.
- R12: Readback may be active at the same time as a write. It then shows the active word, not the word being written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Global output disable, active low, asynchronous |
| cs_n | input | 1 | Chip-select, active low |
| we_n | input | 1 | Staging write strobe, active low |
| re_n | input | 1 | Readback strobe, active low |
| upd_n | input | 1 | Staging-to-active transfer strobe, active low |
| addr | input | 5 | Output address |
| data_i | input | 7 | Write data from the host bus |
| data_o | output | 7 | Readback data to the host bus |
| data_oe | output | 1 | Bus driver enable for data_o |
| sel_o | output | 102 | Input select for each output, 6 bits per output; output k is at bits [6k+5:6k] |
| en_o | output | 17 | Output enable for each output |

## Verification
The block has results with three different latencies. A staging write or an update is visible at the ports one rising edge after its strobes are sampled. Readback is combinational, so it reflects the active word in the same cycle. The global disable clears the enables within the same cycle, with no edge needed. The bench drives each vector at a falling edge and holds the inputs across one rising edge. It then compares data_o, data_oe, en_o and sel_o at the next falling edge, before it changes anything, so each registered result is seen exactly one edge after its stimulus. For the asynchronous clear, the bench lowers rst_n partway through a low clock phase and samples the enables one nanosecond later, before any rising edge arrives.

// File: rtl/xpt_pkg.sv
package xpt_pkg;
  localparam int N_OUT_D  = 17;
  localparam int SEL_W_D  = 6;
  localparam int ADDR_W_D = 5;
endpackage

// File: rtl/xpt_stage_rank.sv
module xpt_stage_rank #(
  parameter int N_OUT  = xpt_pkg::N_OUT_D,
  parameter int WORD_W = xpt_pkg::SEL_W_D + 1,
  parameter int ADDR_W = xpt_pkg::ADDR_W_D
) (
  input  logic                           clk,
  input  logic                           wr_en,
  input  logic [ADDR_W-1:0]              wr_addr,
  input  logic [WORD_W-1:0]              wr_data,
  output logic [N_OUT-1:0][WORD_W-1:0]   stage
);
  // One slot per output; addresses beyond the last slot match none.
  for (genvar g = 0; g < N_OUT; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (wr_en && wr_addr == ADDR_W'(g)) stage[g] <= wr_data;
    end
  end
endmodule

// File: rtl/xpt_active_rank.sv
module xpt_active_rank #(
  parameter int N_OUT = xpt_pkg::N_OUT_D,
  parameter int SEL_W = xpt_pkg::SEL_W_D,
  localparam int WORD_W = SEL_W + 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          load,
  input  logic [N_OUT-1:0][WORD_W-1:0]  stage,
  output logic [N_OUT-1:0][SEL_W-1:0]   sel,
  output logic [N_OUT-1:0]              en
);
  for (genvar g = 0; g < N_OUT; g++) begin : g_out
    // Select field: no reset, loads on every transfer.
    always_ff @(posedge clk) begin
      if (load) sel[g] <= stage[g][SEL_W-1:0];
    end
    // Enable bit: cleared asynchronously, the clear wins over a transfer.
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    en[g] <= 1'b0;
      else if (load) en[g] <= stage[g][SEL_W];
    end
  end
endmodule

// File: rtl/xpt_readback.sv
module xpt_readback #(
  parameter int N_OUT  = xpt_pkg::N_OUT_D,
  parameter int SEL_W  = xpt_pkg::SEL_W_D,
  parameter int ADDR_W = xpt_pkg::ADDR_W_D,
  localparam int WORD_W = SEL_W + 1
) (
  input  logic                         rd_en,
  input  logic [ADDR_W-1:0]            addr,
  input  logic [N_OUT-1:0][SEL_W-1:0]  sel,
  input  logic [N_OUT-1:0]             en,
  output logic                         oe,
  output logic [WORD_W-1:0]            dout
);
  logic [WORD_W-1:0] word;

  always_comb begin
    word = '0;
    for (int i = 0; i < N_OUT; i++) begin
      if (addr == ADDR_W'(i)) word = {en[i], sel[i]};
    end
  end

  assign oe   = rd_en;
  assign dout = rd_en ? word : '0;
endmodule

// File: rtl/xpt_cfg_bank.sv
module xpt_cfg_bank #(
  parameter int N_OUT  = xpt_pkg::N_OUT_D,
  parameter int SEL_W  = xpt_pkg::SEL_W_D,
  parameter int ADDR_W = xpt_pkg::ADDR_W_D,
  localparam int WORD_W = SEL_W + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cs_n,
  input  logic                    we_n,
  input  logic                    re_n,
  input  logic                    upd_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [WORD_W-1:0]       data_i,
  output logic [WORD_W-1:0]       data_o,
  output logic                    data_oe,
  output logic [N_OUT*SEL_W-1:0]  sel_o,
  output logic [N_OUT-1:0]        en_o
);
  logic                         wr_en, load, rd_en;
  logic [N_OUT-1:0][WORD_W-1:0] stage;
  logic [N_OUT-1:0][SEL_W-1:0]  act_sel;
  logic [N_OUT-1:0]             act_en;

  assign wr_en = !cs_n && !we_n;
  assign load  = !cs_n && !upd_n;
  assign rd_en = !cs_n && !re_n;

  xpt_stage_rank #(.N_OUT(N_OUT), .WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_stage (
    .clk(clk), .wr_en(wr_en), .wr_addr(addr), .wr_data(data_i), .stage(stage)
  );

  xpt_active_rank #(.N_OUT(N_OUT), .SEL_W(SEL_W)) u_active (
    .clk(clk), .rst_n(rst_n), .load(load), .stage(stage),
    .sel(act_sel), .en(act_en)
  );

  xpt_readback #(.N_OUT(N_OUT), .SEL_W(SEL_W), .ADDR_W(ADDR_W)) u_rb (
    .rd_en(rd_en), .addr(addr), .sel(act_sel), .en(act_en),
    .oe(data_oe), .dout(data_o)
  );

  assign sel_o = act_sel;
  assign en_o  = act_en;
endmodule

// File: rtl/xpt_cfg_bank_chk.sv
module xpt_cfg_bank_chk #(
  parameter int N_OUT  = 17,
  parameter int SEL_W  = 6,
  parameter int ADDR_W = 5
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   cs_n,
  input logic                   re_n,
  input logic                   upd_n,
  input logic [ADDR_W-1:0]      addr,
  input logic [SEL_W:0]         data_o,
  input logic                   data_oe,
  input logic [N_OUT*SEL_W-1:0] sel_o,
  input logic [N_OUT-1:0]       en_o
);
  // R4
  bus_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n || re_n) |-> (!data_oe && data_o == '0));

  // R7
  oor_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_oe && addr >= ADDR_W'(N_OUT)) |-> data_o == '0);

  // R3
  read_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_oe && addr < ADDR_W'(N_OUT)) |->
      data_o == {en_o[addr], sel_o[addr*SEL_W +: SEL_W]});

  // R5
  en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n || upd_n) |=> $stable(en_o));

  // R5
  sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n || upd_n) |=> $stable(sel_o));

  // R8
  rst_clear_chk: assert property (@(posedge clk)
    !rst_n |-> en_o == '0);
endmodule

bind xpt_cfg_bank xpt_cfg_bank_chk #(.N_OUT(N_OUT), .SEL_W(SEL_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .re_n(re_n), .upd_n(upd_n),
  .addr(addr), .data_o(data_o), .data_oe(data_oe), .sel_o(sel_o), .en_o(en_o)
);

// File: tb/xpt_cfg_bank_bench.sv
`timescale 1ns/1ps
module xpt_cfg_bank_bench;
  localparam int N_OUT = 17;
  localparam int SEL_W = 6;
  localparam int NV    = 14;

  logic clk = 1'b0;
  logic rst_n, cs_n, we_n, re_n, upd_n;
  logic [4:0] addr;
  logic [6:0] data_i, data_o;
  logic data_oe;
  logic [N_OUT*SEL_W-1:0] sel_o;
  logic [N_OUT-1:0] en_o;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  xpt_cfg_bank u_xpt_cfg_bank (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .we_n(we_n), .re_n(re_n),
    .upd_n(upd_n), .addr(addr), .data_i(data_i), .data_o(data_o),
    .data_oe(data_oe), .sel_o(sel_o), .en_o(en_o)
  );

  // {cs_n, we_n, re_n, upd_n, addr[4:0], din[6:0], exp_oe, exp_do[6:0], req[3:0]}
  localparam logic [27:0] VEC [0:NV-1] = '{
    {4'b0011, 5'd0,  7'h45, 1'b0, 7'h00, 4'd1},  // R1 write out0
    {4'b0011, 5'd1,  7'h1F, 1'b0, 7'h00, 4'd1},  // R1 write out1
    {4'b0011, 5'd16, 7'h60, 1'b0, 7'h00, 4'd1},  // R1 write out16
    {4'b0101, 5'd0,  7'h00, 1'b1, 7'h00, 4'd1},  // R1 active rank unchanged
    {4'b0100, 5'd0,  7'h00, 1'b1, 7'h45, 4'd2},  // R2 transfer
    {4'b0101, 5'd1,  7'h00, 1'b1, 7'h1F, 4'd3},  // R3 readback
    {4'b0101, 5'd16, 7'h00, 1'b1, 7'h60, 4'd3},  // R3 readback
    {4'b1000, 5'd0,  7'h7F, 1'b0, 7'h00, 4'd5},  // R5 strobes with cs_n high
    {4'b0100, 5'd0,  7'h00, 1'b1, 7'h45, 4'd5},  // R5 staging untouched
    {4'b0011, 5'd20, 7'h7F, 1'b0, 7'h00, 4'd6},  // R6 write out of range
    {4'b0100, 5'd0,  7'h00, 1'b1, 7'h45, 4'd6},  // R6 out0 unchanged
    {4'b0101, 5'd20, 7'h00, 1'b1, 7'h00, 4'd7},  // R7 readback out of range
    {4'b0000, 5'd0,  7'h02, 1'b1, 7'h45, 4'd11}, // R11 R12 write+update+read
    {4'b0100, 5'd0,  7'h00, 1'b1, 7'h02, 4'd11}  // R11 new word arrives
  };

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cycle();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    cs_n = 1'b1; we_n = 1'b1; re_n = 1'b1; upd_n = 1'b1; addr = '0; data_i = '0;
  endtask

  initial begin
    rst_n = 1'b0;
    idle();
    repeat (3) @(negedge clk);
    check("R8 reset state", 128'(en_o), 128'(0));
    rst_n = 1'b1;
    // Load known zeros in every staging word and transfer them.
    for (int i = 0; i < N_OUT; i++) begin
      cs_n = 1'b0; we_n = 1'b0; addr = 5'(i); data_i = '0;
      cycle();
    end
    we_n = 1'b1; upd_n = 1'b0;
    cycle();
    idle();
    check("R2 initial transfer en", 128'(en_o), 128'(0));
    check("R2 initial transfer sel", 128'(sel_o), 128'(0));

    for (int k = 0; k < NV; k++) begin
      logic [27:0] v;
      v = VEC[k];
      {cs_n, we_n, re_n, upd_n} = v[27:24];
      addr = v[23:19]; data_i = v[18:12];
      cycle();
      check($sformatf("R%0d vec%0d oe", v[3:0], k), 128'(data_oe), 128'(v[11]));
      check($sformatf("R%0d vec%0d data", v[3:0], k), 128'(data_o), 128'(v[10:4]));
    end
    idle();
    check("R2 en export", 128'(en_o), 128'(17'h10000));
    check("R2 sel out0", 128'(sel_o[0 +: SEL_W]), 128'(6'h02));
    check("R2 sel out1", 128'(sel_o[SEL_W +: SEL_W]), 128'(6'h1F));
    check("R2 sel out16", 128'(sel_o[16*SEL_W +: SEL_W]), 128'(6'h20));

    // R8: asynchronous clear with cs_n high
    cs_n = 1'b0; we_n = 1'b0; addr = 5'd3; data_i = 7'h4A;
    cycle();
    we_n = 1'b1; upd_n = 1'b0;
    cycle();
    idle();
    check("R2 out3 enabled", 128'(en_o), 128'(17'h10008));
    #1 rst_n = 1'b0;
    #1;
    check("R8 async clear", 128'(en_o), 128'(0));
    check("R8 select kept", 128'(sel_o[3*SEL_W +: SEL_W]), 128'(6'h0A));
    @(negedge clk);

    // R10: update during reset loads selects, enables stay low
    cs_n = 1'b0; we_n = 1'b0; addr = 5'd3; data_i = 7'h55;
    cycle();
    we_n = 1'b1; upd_n = 1'b0;
    cycle();
    upd_n = 1'b1; re_n = 1'b0; addr = 5'd3;
    #1;
    check("R10 enables low", 128'(en_o), 128'(0));
    check("R10 select loaded", 128'(sel_o[3*SEL_W +: SEL_W]), 128'(6'h15));
    check("R3 readback during reset", 128'(data_o), 128'(7'h15));
    @(negedge clk);
    idle();

    // R9: staging survives the disable
    rst_n = 1'b1;
    cs_n = 1'b0; upd_n = 1'b0;
    cycle();
    idle();
    check("R9 enables restored", 128'(en_o), 128'(17'h10008));

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule